// File: doc/BRIEF.md
# Operand-Indexed Speculative Result Cache

This block is a value-prediction table that is looked up by the operand values of an operation rather than by where the instruction sits in the program. Two different instructions of the same kind that see the same inputs land on the same entry, so a result learned from one of them can be offered as a prediction for the other.

A lookup supplies an operation class, an operation code, a first operand, and either a second register value or a sign-extended immediate offset, chosen by an addressing-mode bit. The two operands are XORed. The low bits of that XOR pick an entry inside the table section that belongs to the class. One clock later the block returns a predict flag and a value. When the operation retires, the same operand set comes back with the true result and a flag saying whether the earlier guess was right. The block then trains the matching entry's confidence, or takes the entry over if it belongs to a different operand set.

Each entry keeps a tag, one result, a 4-bit confidence count and a valid bit. The per-class sections keep the 8:8:1:1:1:1 size ratio. Store and long-latency classes never get an entry.

Top module: `osrc_cache`

## Requirements
- R1: While reset is held and in the first cycle after it, `pred_valid`, `pred_take` and `pred_value` are 0, and every table entry is invalid, so no lookup predicts until an update has been made.
- R2: A lookup presented with `lk_valid` high at clock edge n gives its answer on the outputs after edge n, held until edge n+1. `pred_valid` is high exactly in the cycles that follow a lookup.
- R3: Class encoding is 0 load, 1 add/sub, 2 logical, 3 shift-left, 4 shift-right, 5 set-less-than. Each class owns its own section, with default depths 64, 64, 8, 8, 8, 8. The entry within a section is the low log2(depth) bits of the first operand XOR the second operand.
- R4: When `lk_use_offset` (or `up_use_offset`) is 1, the second operand is the 16-bit offset sign-extended to 32 bits and the register input is ignored. When it is 0, the register input is used and the offset is ignored.
- R5: An entry matches only when its stored addressing mode, operation code, first operand and second operand all equal those of the request. A lookup that does not match gives no prediction.
- R6: `pred_take` is 1 only when the matching entry is valid and its confidence is at least 8. `pred_value` is then the stored result. When `pred_take` is 0, `pred_value` is 0.
- R7: An update that matches a valid entry raises its confidence by 3 when the update is flagged correct, saturating at 15. It lowers the confidence by 1 when flagged incorrect, saturating at 0. In both cases the stored result becomes the retired result.
- R8: An update that does not match a valid entry replaces it: it writes the new tag and result, sets valid, and sets confidence to 0.
- R9: Classes 6 and 7 are never cached. A lookup of either class gives no prediction, and an update of either class changes no entry.
- R10: A lookup and an update in the same cycle see the table as it was before that update; the update's effect shows from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_class | input | 3 | Lookup operation class |
| lk_opc | input | 6 | Lookup operation code |
| lk_src_a | input | 32 | Lookup first operand |
| lk_src_b | input | 32 | Lookup second register operand |
| lk_offset | input | 16 | Lookup immediate offset |
| lk_use_offset | input | 1 | Lookup addressing mode: 1 selects the offset |
| up_valid | input | 1 | Retire update request |
| up_class | input | 3 | Update operation class |
| up_opc | input | 6 | Update operation code |
| up_src_a | input | 32 | Update first operand |
| up_src_b | input | 32 | Update second register operand |
| up_offset | input | 16 | Update immediate offset |
| up_use_offset | input | 1 | Update addressing mode |
| up_result | input | 32 | Actual retired result |
| up_correct | input | 1 | The earlier prediction was right |
| pred_valid | output | 1 | A lookup answer is present |
| pred_take | output | 1 | Prediction offered |
| pred_value | output | 32 | Predicted result, 0 when no prediction |

## Verification
Directed sequences walk one entry's confidence through its thresholds. Reaching exactly 8 and dropping to 7 separates a correct comparison from an off-by-one. Training past 15 and back down, or below 0, shows whether the counter saturates or wraps.

Swapped operands and changed operation codes aim at the same XOR index and show that the tag tells operand sets apart. A changed addressing mode, or a changed unused input, shows which input feeds the second operand. Two operand pairs with equal XOR show replacement on a miss. Updates to uncached classes, and a lookup in the same cycle as an update, cover the remaining corners.

A long seeded random run uses small operand ranges so that entries are shared, trained and evicted often. It is compared cycle by cycle against a bench model of the table.

// File: rtl/osrc_pkg.sv
package osrc_pkg;

    localparam int NUM_SEC = 6;
    localparam int CLASS_W = 3;
    localparam int CONF_W  = 4;

    typedef enum logic [CLASS_W-1:0] {
        CL_LOAD   = 3'd0,
        CL_ADDSUB = 3'd1,
        CL_LOGIC  = 3'd2,
        CL_SHL    = 3'd3,
        CL_SHR    = 3'd4,
        CL_SLT    = 3'd5,
        CL_STORE  = 3'd6,
        CL_LONG   = 3'd7
    } op_class_e;

    // depth of section s out of a packed list of 32-bit depths
    function automatic int sec_depth(input logic [NUM_SEC*32-1:0] deps, input int s);
        return int'(deps[s*32 +: 32]);
    endfunction

    function automatic int sec_base(input logic [NUM_SEC*32-1:0] deps, input int s);
        int acc;
        acc = 0;
        for (int i = 0; i < s; i++) acc += sec_depth(deps, i);
        return acc;
    endfunction

    function automatic int sec_total(input logic [NUM_SEC*32-1:0] deps);
        return sec_base(deps, NUM_SEC);
    endfunction

    function automatic int sec_min(input logic [NUM_SEC*32-1:0] deps);
        int m;
        m = sec_depth(deps, 0);
        for (int i = 1; i < NUM_SEC; i++)
            if (sec_depth(deps, i) < m) m = sec_depth(deps, i);
        return m;
    endfunction

endpackage

// File: rtl/osrc_index.sv
module osrc_index
    import osrc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int OPC_W    = 6,
    parameter int OFF_W    = 16,
    parameter int IDX_W    = 8,
    parameter int MIN_IDXW = 3,
    parameter int TAG_W    = 1 + OPC_W + DATA_W + DATA_W - MIN_IDXW,
    parameter logic [NUM_SEC*32-1:0] SEC_DEPTHS = {6{32'd8}}
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic [OPC_W-1:0]   opc,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [OFF_W-1:0]   offset,
    input  logic               use_offset,
    output logic               cacheable,
    output logic [IDX_W-1:0]   flat_idx,
    output logic [TAG_W-1:0]   tag
);

    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] mixed;
    logic [NUM_SEC-1:0] sec_sel;
    logic [IDX_W-1:0]   sec_idx [NUM_SEC];

    // second operand: sign-extended offset or register value
    assign opnd_b = use_offset ? {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset} : src_b;
    assign mixed  = src_a ^ opnd_b;

    // tag keeps every bit the index does not already pin down
    assign tag = {use_offset, opc, src_a, opnd_b[DATA_W-1:MIN_IDXW]};

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        localparam int DEP  = sec_depth(SEC_DEPTHS, s);
        localparam int BASE = sec_base(SEC_DEPTHS, s);
        assign sec_sel[s] = (cls == CLASS_W'(s));
        assign sec_idx[s] = IDX_W'(BASE) + (mixed[IDX_W-1:0] & IDX_W'(DEP - 1));
    end

    always_comb begin
        flat_idx  = '0;
        cacheable = 1'b0;
        for (int s = 0; s < NUM_SEC; s++) begin
            if (sec_sel[s]) begin
                flat_idx  = sec_idx[s];
                cacheable = 1'b1;
            end
        end
    end

endmodule

// File: rtl/osrc_conf.sv
module osrc_conf #(
    parameter int CONF_W = 4,
    parameter int STEP_UP = 3,
    parameter int STEP_DN = 1
) (
    input  logic [CONF_W-1:0] cur,
    input  logic              correct,
    output logic [CONF_W-1:0] nxt
);

    localparam int MAXV = (1 << CONF_W) - 1;

    logic [CONF_W:0] raised;

    assign raised = {1'b0, cur} + (CONF_W+1)'(STEP_UP);

    always_comb begin
        if (correct) begin
            nxt = (raised > (CONF_W+1)'(MAXV)) ? CONF_W'(MAXV) : raised[CONF_W-1:0];
        end else begin
            nxt = (cur < CONF_W'(STEP_DN)) ? '0 : cur - CONF_W'(STEP_DN);
        end
    end

endmodule

// File: rtl/osrc_cache.sv
module osrc_cache
    import osrc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int OPC_W       = 6,
    parameter int OFF_W       = 16,
    parameter int D_LOAD      = 64,
    parameter int D_ADDSUB    = 64,
    parameter int D_LOGIC     = 8,
    parameter int D_SHL       = 8,
    parameter int D_SHR       = 8,
    parameter int D_SLT       = 8,
    parameter int CONF_UP     = 3,
    parameter int CONF_DN     = 1,
    parameter int CONF_THRESH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [2:0]        lk_class,
    input  logic [OPC_W-1:0]  lk_opc,
    input  logic [DATA_W-1:0] lk_src_a,
    input  logic [DATA_W-1:0] lk_src_b,
    input  logic [OFF_W-1:0]  lk_offset,
    input  logic              lk_use_offset,
    input  logic              up_valid,
    input  logic [2:0]        up_class,
    input  logic [OPC_W-1:0]  up_opc,
    input  logic [DATA_W-1:0] up_src_a,
    input  logic [DATA_W-1:0] up_src_b,
    input  logic [OFF_W-1:0]  up_offset,
    input  logic              up_use_offset,
    input  logic [DATA_W-1:0] up_result,
    input  logic              up_correct,
    output logic              pred_valid,
    output logic              pred_take,
    output logic [DATA_W-1:0] pred_value
);

    localparam logic [NUM_SEC*32-1:0] DEPTHS =
        {32'(D_SLT), 32'(D_SHR), 32'(D_SHL), 32'(D_LOGIC), 32'(D_ADDSUB), 32'(D_LOAD)};
    localparam int TOTAL    = sec_total(DEPTHS);
    localparam int IDX_W    = $clog2(TOTAL);
    localparam int MIN_IDXW = $clog2(sec_min(DEPTHS));
    localparam int TAG_W    = 1 + OPC_W + DATA_W + DATA_W - MIN_IDXW;

    typedef struct packed {
        logic              valid;
        logic [CONF_W-1:0] conf;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] result;
    } entry_t;

    typedef struct packed {
        logic              valid;
        logic              take;
        logic [DATA_W-1:0] value;
    } answer_t;

    entry_t  tbl_q [TOTAL];
    entry_t  tbl_d [TOTAL];
    answer_t ans_q;
    answer_t ans_d;

    logic             lk_cache, up_cache;
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    entry_t           lk_ent, up_ent;
    logic             lk_hit, up_hit;
    logic [CONF_W-1:0] conf_nxt;

    osrc_index #(
        .DATA_W(DATA_W), .OPC_W(OPC_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .MIN_IDXW(MIN_IDXW), .TAG_W(TAG_W), .SEC_DEPTHS(DEPTHS)
    ) u_lk_index (
        .cls(lk_class), .opc(lk_opc), .src_a(lk_src_a), .src_b(lk_src_b),
        .offset(lk_offset), .use_offset(lk_use_offset),
        .cacheable(lk_cache), .flat_idx(lk_idx), .tag(lk_tag)
    );

    osrc_index #(
        .DATA_W(DATA_W), .OPC_W(OPC_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .MIN_IDXW(MIN_IDXW), .TAG_W(TAG_W), .SEC_DEPTHS(DEPTHS)
    ) u_up_index (
        .cls(up_class), .opc(up_opc), .src_a(up_src_a), .src_b(up_src_b),
        .offset(up_offset), .use_offset(up_use_offset),
        .cacheable(up_cache), .flat_idx(up_idx), .tag(up_tag)
    );

    osrc_conf #(
        .CONF_W(CONF_W), .STEP_UP(CONF_UP), .STEP_DN(CONF_DN)
    ) u_conf (
        .cur(up_ent.conf), .correct(up_correct), .nxt(conf_nxt)
    );

    always_comb begin
        tbl_d = tbl_q;
        ans_d = '0;

        // lookup reads the table as it stands before this cycle's update
        lk_ent = tbl_q[lk_idx];
        lk_hit = lk_cache && lk_ent.valid && (lk_ent.tag == lk_tag);
        ans_d.valid = lk_valid;
        if (lk_valid && lk_hit && (lk_ent.conf >= CONF_W'(CONF_THRESH))) begin
            ans_d.take  = 1'b1;
            ans_d.value = lk_ent.result;
        end

        up_ent = tbl_q[up_idx];
        up_hit = up_ent.valid && (up_ent.tag == up_tag);
        if (up_valid && up_cache) begin
            if (up_hit) begin
                tbl_d[up_idx].conf   = conf_nxt;
                tbl_d[up_idx].result = up_result;
            end else begin
                tbl_d[up_idx] = '{valid: 1'b1, conf: '0, tag: up_tag, result: up_result};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) tbl_q[i] <= '0;
            ans_q <= '0;
        end else begin
            for (int i = 0; i < TOTAL; i++) tbl_q[i] <= tbl_d[i];
            ans_q <= ans_d;
        end
    end

    assign pred_valid = ans_q.valid;
    assign pred_take  = ans_q.take;
    assign pred_value = ans_q.value;

endmodule

// File: rtl/osrc_cache_chk.sv
module osrc_cache_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [2:0]        lk_class,
    input logic              pred_valid,
    input logic              pred_take,
    input logic [DATA_W-1:0] pred_value
);

    assert_answer_latency_R2: assert property (
        @(posedge clk) disable iff (!rst_n) pred_valid == $past(lk_valid));

    assert_take_needs_answer_R6: assert property (
        @(posedge clk) disable iff (!rst_n) pred_take |-> pred_valid);

    assert_quiet_value_R6: assert property (
        @(posedge clk) disable iff (!rst_n) !pred_take |-> (pred_value == '0));

    assert_uncached_class_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_class >= 3'd6)) |=> !pred_take);

endmodule

bind osrc_cache osrc_cache_chk #(.DATA_W(DATA_W)) u_osrc_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_class(lk_class),
    .pred_valid(pred_valid), .pred_take(pred_take), .pred_value(pred_value)
);

// File: tb/osrc_cache_bench.sv
`timescale 1ns/1ps
module osrc_cache_bench;

    typedef struct packed {
        logic        v;
        logic [2:0]  c;
        logic [5:0]  o;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] off;
        logic        m;
    } rq_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_use_offset, up_valid, up_use_offset, up_correct;
    logic [2:0]  lk_class, up_class;
    logic [5:0]  lk_opc, up_opc;
    logic [31:0] lk_src_a, lk_src_b, up_src_a, up_src_b, up_result;
    logic [15:0] lk_offset, up_offset;
    logic        pred_valid, pred_take;
    logic [31:0] pred_value;

    int checks = 0;
    int errors = 0;

    // bench model of the table
    bit          mv [160];
    bit          mm [160];
    bit [5:0]    mo [160];
    bit [31:0]   ma [160];
    bit [31:0]   mb [160];
    bit [31:0]   mr [160];
    int          mc [160];

    always #2 clk = ~clk;

    osrc_cache u_osrc_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_class(lk_class), .lk_opc(lk_opc),
        .lk_src_a(lk_src_a), .lk_src_b(lk_src_b), .lk_offset(lk_offset),
        .lk_use_offset(lk_use_offset),
        .up_valid(up_valid), .up_class(up_class), .up_opc(up_opc),
        .up_src_a(up_src_a), .up_src_b(up_src_b), .up_offset(up_offset),
        .up_use_offset(up_use_offset), .up_result(up_result), .up_correct(up_correct),
        .pred_valid(pred_valid), .pred_take(pred_take), .pred_value(pred_value)
    );

    function automatic logic [31:0] second_op(input rq_t r);
        return r.m ? {{16{r.off[15]}}, r.off} : r.b;
    endfunction

    function automatic int model_idx(input rq_t r);
        int base [6] = '{0, 64, 128, 136, 144, 152};
        int dep  [6] = '{64, 64, 8, 8, 8, 8};
        logic [31:0] x;
        if (r.c > 3'd5) return -1;
        x = r.a ^ second_op(r);
        return base[r.c] + int'(x & 32'(dep[r.c] - 1));
    endfunction

    function automatic bit model_match(input rq_t r, input int i);
        return mv[i] && (mm[i] == r.m) && (mo[i] == r.o) && (ma[i] == r.a) &&
               (mb[i] == second_op(r));
    endfunction

    function automatic rq_t mk(input int c, input int o, input logic [31:0] a,
                               input logic [31:0] b, input logic [15:0] off, input bit m);
        rq_t r;
        r.v = 1'b1; r.c = 3'(c); r.o = 6'(o); r.a = a; r.b = b; r.off = off; r.m = m;
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at a falling edge, check the answer one cycle later
    task automatic step(input rq_t lk, input rq_t up, input logic [31:0] res,
                        input bit corr, input string req);
        int li, ui;
        bit etake;
        logic [31:0] evalue;
        lk_valid = lk.v; lk_class = lk.c; lk_opc = lk.o; lk_src_a = lk.a;
        lk_src_b = lk.b; lk_offset = lk.off; lk_use_offset = lk.m;
        up_valid = up.v; up_class = up.c; up_opc = up.o; up_src_a = up.a;
        up_src_b = up.b; up_offset = up.off; up_use_offset = up.m;
        up_result = res; up_correct = corr;
        etake = 1'b0; evalue = '0;
        li = model_idx(lk);
        if (lk.v && li >= 0 && model_match(lk, li) && mc[li] >= 8) begin
            etake = 1'b1; evalue = mr[li];
        end
        ui = model_idx(up);
        if (up.v && ui >= 0) begin
            if (model_match(up, ui)) begin
                mc[ui] = corr ? ((mc[ui] + 3 > 15) ? 15 : mc[ui] + 3)
                              : ((mc[ui] < 1) ? 0 : mc[ui] - 1);
                mr[ui] = res;
            end else begin
                mv[ui] = 1'b1; mm[ui] = up.m; mo[ui] = up.o; ma[ui] = up.a;
                mb[ui] = second_op(up); mr[ui] = res; mc[ui] = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "pred_valid", 32'(pred_valid), 32'(lk.v));
        chk(req, "pred_take", 32'(pred_take), 32'(etake));
        chk(req, "pred_value", pred_value, evalue);
        lk_valid = 1'b0; up_valid = 1'b0;
    endtask

    task automatic look(input rq_t r, input string req);
        step(r, '0, '0, 1'b0, req);
    endtask

    task automatic upd(input rq_t r, input logic [31:0] res, input bit corr, input string req);
        step('0, r, res, corr, req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rq_t r, rs, r2, r3, r4, r5, r6, r7;
        void'($urandom(32'd2024));
        for (int i = 0; i < 160; i++) begin
            mv[i] = 0; mm[i] = 0; mo[i] = 0; ma[i] = 0; mb[i] = 0; mr[i] = 0; mc[i] = 0;
        end
        rst_n = 1'b0;
        lk_valid = 0; lk_class = 0; lk_opc = 0; lk_src_a = 0; lk_src_b = 0;
        lk_offset = 0; lk_use_offset = 0;
        up_valid = 0; up_class = 0; up_opc = 0; up_src_a = 0; up_src_b = 0;
        up_offset = 0; up_use_offset = 0; up_result = 0; up_correct = 0;
        repeat (3) @(negedge clk);
        chk("R1", "pred_valid in reset", 32'(pred_valid), 0);
        chk("R1", "pred_take in reset", 32'(pred_take), 0);
        chk("R1", "pred_value in reset", pred_value, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pred_valid after reset", 32'(pred_valid), 0);

        // R1 / R3: empty table, then install and train
        r = mk(1, 1, 32'h10, 32'h3, 16'h0, 0);
        look(r, "R1");
        upd(r, 32'hAAAA, 1, "R8");
        look(r, "R8");
        upd(r, 32'hAAAA, 1, "R7");
        upd(r, 32'hAAAA, 1, "R7");
        look(r, "R6");
        upd(r, 32'hAAAA, 1, "R7");
        look(r, "R3");
        // R6 threshold boundary: 9 -> 8 predicts, 8 -> 7 does not
        upd(r, 32'hAAAA, 0, "R7");
        look(r, "R6");
        upd(r, 32'hAAAA, 0, "R7");
        look(r, "R6");

        // R7 top saturation
        r2 = mk(0, 2, 32'h100, 32'h20, 16'h0, 0);
        upd(r2, 32'h5, 1, "R8");
        for (int i = 0; i < 6; i++) upd(r2, 32'h5, 1, "R7");
        for (int i = 0; i < 7; i++) upd(r2, 32'h5, 0, "R7");
        look(r2, "R7");
        upd(r2, 32'h5, 0, "R7");
        look(r2, "R7");

        // R7 bottom saturation
        r3 = mk(2, 0, 32'h7, 32'h1, 16'h0, 0);
        upd(r3, 32'h9, 1, "R8");
        upd(r3, 32'h9, 0, "R7");
        look(r3, "R7");

        // R5 tag: swapped operands, other opcode, other class
        upd(r, 32'hAAAA, 1, "R7");
        look(r, "R5");
        rs = mk(1, 1, 32'h3, 32'h10, 16'h0, 0);
        look(rs, "R5");
        rs = mk(1, 2, 32'h10, 32'h3, 16'h0, 0);
        look(rs, "R5");
        rs = mk(0, 1, 32'h10, 32'h3, 16'h0, 0);
        look(rs, "R3");

        // R4 offset mode with sign extension; register input ignored
        r4 = mk(0, 3, 32'h40, 32'hDEAD0000, 16'hFFFC, 1);
        upd(r4, 32'h1234, 1, "R8");
        for (int i = 0; i < 3; i++) upd(r4, 32'h1234, 1, "R7");
        look(mk(0, 3, 32'h40, 32'h0, 16'hFFFC, 1), "R4");
        look(mk(0, 3, 32'h40, 32'hFFFFFFFC, 16'h0, 0), "R4");
        // R4 register mode; offset ignored
        r5 = mk(1, 4, 32'h200, 32'h33, 16'h0, 0);
        upd(r5, 32'h4321, 1, "R8");
        for (int i = 0; i < 3; i++) upd(r5, 32'h4321, 1, "R7");
        look(mk(1, 4, 32'h200, 32'h33, 16'h55, 0), "R4");

        // R8 replacement by another pair with the same XOR
        r6 = mk(3, 0, 32'h1, 32'h2, 16'h0, 0);
        for (int i = 0; i < 4; i++) upd(r6, 32'h66, 1, "R7");
        look(r6, "R8");
        r7 = mk(3, 0, 32'h9, 32'hA, 16'h0, 0);
        upd(r7, 32'h77, 1, "R8");
        look(r7, "R8");
        look(r6, "R8");
        for (int i = 0; i < 3; i++) upd(r7, 32'h77, 1, "R7");
        look(r7, "R8");

        // R7 result overwrite on an incorrect update
        upd(r, 32'hBBBB, 0, "R7");
        look(r, "R7");

        // R9 uncached classes
        upd(mk(6, 1, 32'h10, 32'h3, 16'h0, 0), 32'hCCCC, 0, "R9");
        upd(mk(7, 1, 32'h10, 32'h3, 16'h0, 0), 32'hCCCC, 0, "R9");
        look(r, "R9");
        look(mk(6, 1, 32'h10, 32'h3, 16'h0, 0), "R9");
        look(mk(7, 1, 32'h10, 32'h3, 16'h0, 0), "R9");

        // R10 lookup and update together
        step(r, r, 32'hDDDD, 0, "R10");
        look(r, "R10");

        // R2 / R3 / R5 / R6 / R7 / R8 random mix against the model
        for (int n = 0; n < 4000; n++) begin
            rq_t q, u;
            bit doq, dou;
            doq = ($urandom_range(0, 3) != 0);
            dou = ($urandom_range(0, 2) != 0);
            q = mk($urandom_range(0, 7), $urandom_range(0, 2), 32'($urandom_range(0, 7)),
                   32'($urandom_range(0, 5)), 16'($urandom_range(0, 3)) - 16'd1,
                   bit'($urandom_range(0, 1)));
            u = mk($urandom_range(0, 7), $urandom_range(0, 2), 32'($urandom_range(0, 7)),
                   32'($urandom_range(0, 5)), 16'($urandom_range(0, 3)) - 16'd1,
                   bit'($urandom_range(0, 1)));
            if (!doq) q = '0;
            if (!dou) u = '0;
            step(q, u, $urandom, bit'($urandom_range(0, 3) != 0), "R2");
        end

        finish_run();
    end

endmodule